// File: doc/BRIEF.md
# Reset Cause and Event Flag Register

This block is an 8-bit status register that a processor reads to find out why it last came out of reset. It also holds three sticky interrupt flags and shows two live status levels. Three of its bits record reset causes: power-up, supply brown-out and an access to an illegal address. Each of these reacts in its own way to a power-on reset and to an ordinary system reset. The block does not detect reset conditions and raises no interrupts. It only stores the flags and applies the rules that set and clear them.

Software reads the byte at any time. Flags are cleared by writing 1 to their bit positions, and writing 0 changes nothing. Events arrive as one-cycle pulses (brown-out reset, illegal-address reset, real-time tick). The lock and oscillator-ready indications arrive as levels. A change of either level, in either direction, raises the matching interrupt flag. A power-on reset is the block's full synchronous initialisation. A system reset is a lighter reset that leaves the reset-cause flags in place, so that software can read them afterwards.

Top module: `rst_cause_reg`

## Requirements
- R1: In the cycle after a clock edge with `por_i` high, the byte reads bit6 (power-up flag) = 1, bit5 (brown-out flag) = 1, bit2 (illegal-address flag) = 0, and bits 7, 4 and 1 (interrupt flags) = 0.
- R2: While `sys_rst_i` is high and `por_i` is low, writes are ignored. Bits 6, 5 and 2 keep their values, except that a brown-out or illegal-address event in the same cycle still sets its flag.
- R3: A clock edge with `sys_rst_i` high and `por_i` low clears bits 7, 4 and 1, even if a level change or tick arrives in that cycle.
- R4: Outside any reset, a `lvr_evt_i` pulse sets bit5, an `iar_evt_i` pulse sets bit2 and an `rti_evt_i` pulse sets bit7. Each flag reads 1 from the next cycle on.
- R5: A write with `wr_en_i` high clears every flag bit (7, 6, 5, 4, 2, 1) whose data bit is 1. Flag bits whose data bit is 0 keep their values.
- R6: Bit3 always reads the current `lock_i` level and bit0 always reads the current `osc_up_i` level. Writes to these positions have no effect.
- R7: Outside any reset, a change of `lock_i` between consecutive clock edges sets bit4, and a change of `osc_up_i` sets bit1. A level held steady sets neither flag.
- R8: When a set event and a write-1-to-clear hit the same flag at the same clock edge, the flag reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| sys_rst_i | input | 1 | System reset, synchronous, active high |
| lvr_evt_i | input | 1 | Brown-out reset event pulse |
| iar_evt_i | input | 1 | Illegal-address reset event pulse |
| rti_evt_i | input | 1 | Real-time tick event pulse |
| lock_i | input | 1 | Clock-lock status level |
| osc_up_i | input | 1 | Oscillator-ready status level |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data, a 1 clears the flag in that position |
| rd_data_o | output | 8 | Register read value |

## Verification
The bench goes after the collisions between rules. A flag set and cleared at the same edge must stay set; a design that let the clear win would silently lose an event. The bench also writes all ones during a system reset. A design that did not gate writes there would wipe the cause flags, and one that obeyed reset too broadly would clear them too. Level changes are driven in both directions and during a system reset, which exposes rising-only detection and set-over-reset priority errors. A second power-on reset with the illegal-address flag set shows whether that flag is really cleared rather than kept.

// File: rtl/rstflg_pkg.sv
package rstflg_pkg;

    localparam int REG_W = 8;

    // bit positions of the readable byte (software decodes these)
    localparam int POS_RTI = 7;
    localparam int POS_PWR = 6;
    localparam int POS_LV  = 5;
    localparam int POS_LKI = 4;
    localparam int POS_LK  = 3;
    localparam int POS_ILL = 2;
    localparam int POS_OSI = 1;
    localparam int POS_OSU = 0;

    // watched status levels
    localparam int LVL_W   = 2;
    localparam int LVL_LK  = 1;
    localparam int LVL_OSU = 0;

    typedef enum logic [1:0] {
        RULE_KEEP  = 2'd0,
        RULE_SET   = 2'd1,
        RULE_CLEAR = 2'd2
    } rst_rule_e;

    typedef struct packed {
        logic rti;
        logic pwr;
        logic lv;
        logic lki;
        logic lk;
        logic ill;
        logic osi;
        logic osu;
    } stat_byte_t;

    function automatic bit is_live(int b);
        return (b == POS_LK) || (b == POS_OSU);
    endfunction

    function automatic rst_rule_e por_rule(int b);
        if (b == POS_PWR || b == POS_LV) return RULE_SET;
        return RULE_CLEAR;
    endfunction

    function automatic rst_rule_e sys_rule(int b);
        if (b == POS_RTI || b == POS_LKI || b == POS_OSI) return RULE_CLEAR;
        return RULE_KEEP;
    endfunction

    function automatic logic apply_rule(rst_rule_e r, logic cur);
        case (r)
            RULE_SET:   return 1'b1;
            RULE_CLEAR: return 1'b0;
            default:    return cur;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] flag_mask();
        logic [REG_W-1:0] m;
        for (int b = 0; b < REG_W; b++) m[b] = !is_live(b);
        return m;
    endfunction

    localparam logic [REG_W-1:0] CLR_MASK = flag_mask();

endpackage

// File: rtl/rstflg_cell.sv
module rstflg_cell
    import rstflg_pkg::*;
#(
    parameter rst_rule_e POR_RULE = RULE_CLEAR,
    parameter rst_rule_e SYS_RULE = RULE_KEEP
) (
    input  logic clk,
    input  logic por_i,
    input  logic sys_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    localparam bit SYS_ACTS = (SYS_RULE != RULE_KEEP);

    always_ff @(posedge clk) begin
        if (por_i)
            q_o <= apply_rule(POR_RULE, q_o);
        else if (sys_i && SYS_ACTS)
            q_o <= apply_rule(SYS_RULE, q_o);
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

endmodule

// File: rtl/rstflg_edge.sv
module rstflg_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] chg_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
    end

    assign chg_o = por_i ? '0 : (lvl_i ^ prev_q);

endmodule

// File: rtl/rstflg_wdec.sv
module rstflg_wdec
    import rstflg_pkg::*;
(
    input  logic             wr_en_i,
    input  logic             por_i,
    input  logic             sys_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] clr_o
);

    logic wr_ok;

    assign wr_ok = wr_en_i && !por_i && !sys_i;
    assign clr_o = wr_ok ? (wr_data_i & CLR_MASK) : '0;

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rstflg_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic             sys_rst_i,
    input  logic             lvr_evt_i,
    input  logic             iar_evt_i,
    input  logic             rti_evt_i,
    input  logic             lock_i,
    input  logic             osc_up_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o
);

    logic [LVL_W-1:0] lvl_v;
    logic [LVL_W-1:0] chg_v;
    stat_byte_t       set_s;
    stat_byte_t       live_s;
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] live_v;
    logic [REG_W-1:0] clr_v;
    logic [REG_W-1:0] flag_q;

    assign lvl_v[LVL_LK]  = lock_i;
    assign lvl_v[LVL_OSU] = osc_up_i;

    rstflg_edge #(.W(LVL_W)) u_edge (
        .clk   (clk),
        .por_i (por_i),
        .lvl_i (lvl_v),
        .chg_o (chg_v)
    );

    rstflg_wdec u_wdec (
        .wr_en_i   (wr_en_i),
        .por_i     (por_i),
        .sys_i     (sys_rst_i),
        .wr_data_i (wr_data_i),
        .clr_o     (clr_v)
    );

    always_comb begin
        set_s     = '0;
        set_s.rti = rti_evt_i;
        set_s.lv  = lvr_evt_i;
        set_s.ill = iar_evt_i;
        set_s.lki = chg_v[LVL_LK];
        set_s.osi = chg_v[LVL_OSU];

        live_s     = '0;
        live_s.lk  = lock_i;
        live_s.osu = osc_up_i;
    end

    assign set_v  = set_s;
    assign live_v = live_s;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (is_live(b)) begin : g_live
            assign flag_q[b] = 1'b0;
        end else begin : g_flag
            rstflg_cell #(
                .POR_RULE (por_rule(b)),
                .SYS_RULE (sys_rule(b))
            ) u_cell (
                .clk   (clk),
                .por_i (por_i),
                .sys_i (sys_rst_i),
                .set_i (set_v[b]),
                .clr_i (clr_v[b]),
                .q_o   (flag_q[b])
            );
        end
    end

    // live positions take neither set nor clear; fold the idle bits together
    logic unused_tie;
    assign unused_tie = set_v[POS_LK] ^ set_v[POS_OSU] ^ clr_v[POS_LK] ^ clr_v[POS_OSU];

    assign rd_data_o = flag_q | live_v;

endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk (
    input logic       clk,
    input logic       por_i,
    input logic       sys_rst_i,
    input logic       lvr_evt_i,
    input logic       iar_evt_i,
    input logic       rti_evt_i,
    input logic       lock_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o
);

    logic seen_q = 1'b0;
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (por_i) seen_q <= 1'b1;
        armed_q <= seen_q;
    end

    assert_por_init_R1: assert property (@(posedge clk) disable iff (!seen_q)
        por_i |=> (rd_data_o[6] && rd_data_o[5] && !rd_data_o[2]
                   && !rd_data_o[7] && !rd_data_o[4] && !rd_data_o[1]));

    assert_sys_keeps_cause_R2: assert property (@(posedge clk) disable iff (!armed_q || por_i)
        (sys_rst_i && !lvr_evt_i && !iar_evt_i) |=>
            ((rd_data_o[6] == $past(rd_data_o[6])) && (rd_data_o[5] == $past(rd_data_o[5]))
             && (rd_data_o[2] == $past(rd_data_o[2]))));

    assert_sys_clears_irq_R3: assert property (@(posedge clk) disable iff (!armed_q || por_i)
        sys_rst_i |=> (!rd_data_o[7] && !rd_data_o[4] && !rd_data_o[1]));

    assert_lvr_sets_R4: assert property (@(posedge clk) disable iff (!armed_q || por_i)
        lvr_evt_i |=> rd_data_o[5]);

    assert_w1c_pwr_R5: assert property (@(posedge clk) disable iff (!armed_q || por_i)
        (!sys_rst_i && wr_en_i && wr_data_i[6]) |=> !rd_data_o[6]);

    assert_lock_change_R7: assert property (@(posedge clk) disable iff (!armed_q || por_i)
        (!sys_rst_i && (lock_i != $past(lock_i))) |=> rd_data_o[4]);

    assert_set_beats_clr_R8: assert property (@(posedge clk) disable iff (!armed_q || por_i)
        (!sys_rst_i && rti_evt_i && wr_en_i && wr_data_i[7]) |=> rd_data_o[7]);

endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (
    .clk       (clk),
    .por_i     (por_i),
    .sys_rst_i (sys_rst_i),
    .lvr_evt_i (lvr_evt_i),
    .iar_evt_i (iar_evt_i),
    .rti_evt_i (rti_evt_i),
    .lock_i    (lock_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o)
);

// File: tb/rst_cause_reg_tb_top.sv
`timescale 1ns/1ps
module rst_cause_reg_tb_top;

    logic       clk = 1'b0;
    logic       por_i = 1'b0;
    logic       sys_rst_i = 1'b0;
    logic       lvr_evt_i = 1'b0;
    logic       iar_evt_i = 1'b0;
    logic       rti_evt_i = 1'b0;
    logic       lock_i = 1'b0;
    logic       osc_up_i = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;

    always #2 clk = ~clk;

    rst_cause_reg dut_i (
        .clk       (clk),
        .por_i     (por_i),
        .sys_rst_i (sys_rst_i),
        .lvr_evt_i (lvr_evt_i),
        .iar_evt_i (iar_evt_i),
        .rti_evt_i (rti_evt_i),
        .lock_i    (lock_i),
        .osc_up_i  (osc_up_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the stored flags, built from the requirements
    logic m_rti, m_pwr, m_lv, m_lki, m_ill, m_osi;
    logic m_prev_lk, m_prev_osc;

    task automatic model_edge();
        logic chg_lk, chg_osc;
        if (por_i) begin
            m_rti = 0; m_pwr = 1; m_lv = 1; m_lki = 0; m_ill = 0; m_osi = 0;
        end else begin
            chg_lk  = (lock_i != m_prev_lk);
            chg_osc = (osc_up_i != m_prev_osc);
            if (sys_rst_i) begin
                m_rti = 0; m_lki = 0; m_osi = 0;
                if (lvr_evt_i) m_lv = 1;
                if (iar_evt_i) m_ill = 1;
            end else begin
                m_rti = rti_evt_i ? 1'b1 : ((wr_en_i && wr_data_i[7]) ? 1'b0 : m_rti);
                m_pwr = (wr_en_i && wr_data_i[6]) ? 1'b0 : m_pwr;
                m_lv  = lvr_evt_i ? 1'b1 : ((wr_en_i && wr_data_i[5]) ? 1'b0 : m_lv);
                m_lki = chg_lk ? 1'b1 : ((wr_en_i && wr_data_i[4]) ? 1'b0 : m_lki);
                m_ill = iar_evt_i ? 1'b1 : ((wr_en_i && wr_data_i[2]) ? 1'b0 : m_ill);
                m_osi = chg_osc ? 1'b1 : ((wr_en_i && wr_data_i[1]) ? 1'b0 : m_osi);
            end
        end
        m_prev_lk  = lock_i;
        m_prev_osc = osc_up_i;
    endtask

    // driver: one clock edge with the inputs set up by the caller
    task automatic step(input string tag);
        item_t it;
        @(posedge clk);
        model_edge();
        it.exp = {m_rti, m_pwr, m_lv, m_lki, lock_i, m_ill, m_osi, osc_up_i};
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        lvr_evt_i = 0; iar_evt_i = 0; rti_evt_i = 0;
        wr_en_i = 0; wr_data_i = 8'h00;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1; wr_data_i = d;
    endtask

    // monitor: compares one sample per edge, 1 ns after it
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                it = q.pop_front();
                n_chk++;
                if (rd_data_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: rd_data=%02h expected=%02h", it.tag, rd_data_o, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: power-on initialisation
        por_i = 1;
        step("R1 por first edge");
        step("R1 por second edge");
        por_i = 0;
        step("R1 state after por");

        // R5: zero write leaves flags, ones clear them
        wr(8'h00); step("R5 write zero no effect");
        wr(8'h40); step("R5 clear power flag");
        wr(8'h20); step("R5 clear brown-out flag");

        // R4: event pulses set flags
        lvr_evt_i = 1; step("R4 brown-out sets bit5");
        iar_evt_i = 1; step("R4 illegal-address sets bit2");
        rti_evt_i = 1; step("R4 tick sets bit7");

        // R6: live bits ignore writes and follow inputs
        wr(8'h09); step("R6 write to status bits");
        lock_i = 1; osc_up_i = 0; step("R6 R7 levels change");
        step("R7 levels held");
        wr(8'h12); step("R7 clear change flags");
        step("R7 held level sets nothing");
        lock_i = 0; step("R7 falling lock sets bit4");
        osc_up_i = 1; step("R7 rising osc sets bit1");
        step("R6 live bits steady");

        // R8: set beats clear
        rti_evt_i = 1; wr(8'h80); step("R8 tick vs clear");
        lvr_evt_i = 1; wr(8'h20); step("R8 brown-out vs clear");
        iar_evt_i = 1; wr(8'h04); step("R8 illegal-address vs clear");

        // R2/R3: system reset
        wr(8'h40); step("R5 clear power flag again");
        sys_rst_i = 1; wr(8'hFF); step("R2 R3 sys reset with write");
        lock_i = 1; step("R3 lock change during sys reset");
        sys_rst_i = 0; wr(8'h20); step("R5 clear brown-out after sys");
        sys_rst_i = 1; lvr_evt_i = 1; step("R2 brown-out during sys reset");
        rti_evt_i = 1; step("R3 tick during sys reset");
        sys_rst_i = 0; step("R2 after sys reset");

        // R1: second power-on clears illegal-address flag
        rti_evt_i = 1; step("R4 tick before por");
        por_i = 1; osc_up_i = 0; step("R1 second por");
        por_i = 0; step("R1 after second por");
        step("R7 no spurious change after por");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule